// File: doc/BRIEF.md
# Display List Walker

The walker sequences the display lists of three compositor channels out of a shared, word-addressed list memory of 4096 32-bit words. Each channel keeps a start-pointer register. When a frame start arrives for an armed channel, the walker reads the control word at the captured pointer and streams that entry's words, control word included, to a downstream plane-fetch stage. It then jumps to the next entry by adding the entry's size field to the entry's start address. It stops at a control word that carries the end marker, and that word is not streamed.

Only one channel is walked at a time. When several frame starts are pending, the lowest-numbered channel wins and its whole list is streamed before the next channel is picked up. A control word with a zero size, or a walk that runs past the top of the memory, stops the channel and raises a sticky per-channel error. The memory is read through a synchronous port with one cycle of latency. A host write port passes through a guard that protects the 32 reserved words at the bottom of the memory.

Top module: `dl_walker`

## Requirements
- R1: After reset every channel reports mode 0 (disabled), every error flag is 0, `out_valid` is 0 and `mem_rd_en` is 0.
- R2: A disabled channel whose enable is high moves to mode 1 (armed) on the next clock. A walk uses the start pointer held when the walker picks the channel up, and a pointer load during that walk does not change the words streamed.
- R3: Each entry is streamed as SIZE consecutive words read from its start address upward. `out_first` is set only on the control word and `out_last` only on the final word, so a SIZE of 1 sets both on one word. `out_chan` carries the channel number.
- R4: The control word holds the end marker in bit 31 and SIZE in bits 29:24. The next entry starts at the entry start plus SIZE. A control word with bit 31 set ends the walk and is not streamed, so a list that begins with it streams nothing.
- R5: A walk that ends cleanly returns the channel to mode 1 (armed) when its one-shot input is low, and to mode 3 (end of frame) when it is high. While a channel is being walked it reports mode 2 (active).
- R6: A frame start is ignored for a channel in mode 0 or mode 3: no words are streamed and the mode is unchanged.
- R7: While `out_valid` is high and `out_ready` is low, the valid flag, data, markers and channel number hold steady.
- R8: Pending channels are served one at a time with channel 0 first, then 1, then 2. Each served channel streams its whole list before the next channel starts.
- R9: A non-end control word with SIZE 0 stops the walk. Nothing is streamed for it, the channel's error flag is set and the channel moves to mode 3. The flag stays set until the channel is disabled.
- R10: An entry that would run past word 4095 stops the walk with the error flag set and is not streamed. An entry that ends exactly at word 4095 is streamed and then raises the error flag.
- R11: A host write to an address below 32 never reaches the memory write port (`mem_wr_en` stays 0). Writes at address 32 or above pass through in the same cycle.
- R12: Dropping a channel's enable while it is not being walked moves it to mode 0 and clears its error flag on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_enable | input | 3 | Per-channel enable |
| ch_oneshot | input | 3 | Per-channel one-shot select (stop in mode 3 after one frame) |
| frame_start | input | 3 | Per-channel frame start pulse |
| ptr_load | input | 3 | Per-channel start-pointer load strobe |
| ptr_data | input | 12 | Start pointer value (word index) |
| ch_mode | output | 6 | Per-channel mode, 2 bits each, channel 0 in bits 1:0 |
| ch_err | output | 3 | Per-channel sticky error flag |
| mem_rd_en | output | 1 | List memory read enable |
| mem_rd_addr | output | 12 | List memory read address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the read |
| host_wr_en | input | 1 | Host write request |
| host_wr_addr | input | 12 | Host write address |
| host_wr_data | input | 32 | Host write data |
| mem_wr_en | output | 1 | Guarded memory write enable |
| mem_wr_addr | output | 12 | Memory write address |
| mem_wr_data | output | 32 | Memory write data |
| out_valid | output | 1 | Entry word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Entry word |
| out_first | output | 1 | Word is an entry's control word |
| out_last | output | 1 | Word is an entry's final word |
| out_chan | output | 2 | Channel that owns the word |

## Verification
Mode and error changes are due on the clock edge after the enable or frame start is sampled. The first streamed word follows three edges after the walker picks up the channel: capture, read and latch. Every later word takes at least three edges, plus any cycles spent stalled. The guarded write enable is combinational and is checked in the same cycle as its inputs. The bench drives and samples on the falling edge, so each mode check lands one full edge after its stimulus. The stream is collected as ordered transactions at handshake edges and compared to a list model walked over the bench's own memory image, so word order and markers are checked without fixing their absolute cycle. Waits for a walk to finish poll the mode output with a bound.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

    typedef enum logic [1:0] {
        MODE_DISABLED = 2'd0,
        MODE_ARMED    = 2'd1,
        MODE_ACTIVE   = 2'd2,
        MODE_EOF      = 2'd3
    } ch_mode_e;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_FETCH = 2'd1,
        WS_LATCH = 2'd2,
        WS_SEND  = 2'd3
    } walk_state_e;

endpackage

// File: rtl/dlw_chan_ctrl.sv
module dlw_chan_ctrl
    import dlw_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          oneshot,
    input  logic          frame_start,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_data,
    input  logic          grant,
    input  logic          done,
    input  logic          fault,
    output ch_mode_e      mode,
    output logic          err,
    output logic          req,
    output logic          busy,
    output logic [AW-1:0] ptr
);

    typedef struct packed {
        ch_mode_e      mode;
        logic          err;
        logic          busy;
        logic [AW-1:0] ptr;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ptr_load) begin
            st_d.ptr = ptr_data;
        end
        if (!enable && !st_q.busy) begin
            st_d.mode = MODE_DISABLED;
            st_d.err  = 1'b0;
        end else begin
            unique case (st_q.mode)
                MODE_DISABLED: begin
                    if (enable) st_d.mode = MODE_ARMED;
                end
                MODE_ARMED: begin
                    if (frame_start) st_d.mode = MODE_ACTIVE;
                end
                MODE_ACTIVE: begin
                    if (grant) st_d.busy = 1'b1;
                    if (done) begin
                        st_d.busy = 1'b0;
                        if (fault) begin
                            st_d.err  = 1'b1;
                            st_d.mode = MODE_EOF;
                        end else begin
                            st_d.mode = oneshot ? MODE_EOF : MODE_ARMED;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_DISABLED, err: 1'b0, busy: 1'b0, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
    assign err  = st_q.err;
    assign busy = st_q.busy;
    assign ptr  = st_q.ptr;
    assign req  = (st_q.mode == MODE_ACTIVE) && !st_q.busy;

    // R6: a stopped channel stays stopped while enabled
    p_eof_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_EOF && enable) |=> (st_q.mode == MODE_EOF));

    // R9: a raised error always comes with a stopped channel
    p_err_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> (st_q.mode == MODE_EOF));

    // R12: disabling an idle channel clears it
    p_disable_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !st_q.busy) |=> (st_q.mode == MODE_DISABLED && !st_q.err));

endmodule

// File: rtl/dlw_arbiter.sv
module dlw_arbiter #(
    parameter int NCH = 3,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] grant,
    output logic [CHW-1:0] idx,
    output logic           any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = CHW'(i);
            end
        end
    end

    assign any = |req;

    // R8: never a grant to a channel while a lower-numbered one is requesting
    always_comb begin
        for (int i = 1; i < NCH; i++) begin
            if (grant[i]) begin
                p_prio_r8: assert ((req & ((NCH'(1) << i) - NCH'(1))) == '0);
            end
        end
    end

endmodule

// File: rtl/dlw_seq.sv
module dlw_seq
    import dlw_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int NCH      = 3,
    parameter int END_BIT  = 31,
    parameter int SIZE_LSB = 24,
    parameter int SIZE_W   = 6,
    localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PW      = AW + 1,
    localparam int DEPTH   = 1 << AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_req,
    input  logic [CHW-1:0] req_idx,
    input  logic [AW-1:0]  req_ptr,
    output logic           take,
    output logic           done,
    output logic           fault,
    output logic [CHW-1:0] cur_ch,
    output logic           mem_rd_en,
    output logic [AW-1:0]  mem_rd_addr,
    input  logic [DW-1:0]  mem_rd_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [DW-1:0]  out_data,
    output logic           out_first,
    output logic           out_last,
    output logic [CHW-1:0] out_chan
);

    localparam logic [PW-1:0] TOP = PW'(DEPTH);

    typedef struct packed {
        walk_state_e   st;
        logic [CHW-1:0] ch;
        logic [PW-1:0] addr;
        logic [PW-1:0] ent_next;
        logic [SIZE_W-1:0] remain;
        logic          first;
        logic          last;
        logic          valid;
        logic [DW-1:0] data;
    } seq_st_t;

    seq_st_t sq_d, sq_q;

    logic [SIZE_W-1:0] ctl_size;
    logic [PW-1:0]     ctl_next;
    logic [SIZE_W-1:0] rem_new;

    assign ctl_size = mem_rd_data[SIZE_LSB +: SIZE_W];
    assign ctl_next = sq_q.addr + PW'(ctl_size);

    always_comb begin
        sq_d    = sq_q;
        take    = 1'b0;
        done    = 1'b0;
        fault   = 1'b0;
        rem_new = sq_q.remain;
        unique case (sq_q.st)
            WS_IDLE: begin
                if (any_req) begin
                    take        = 1'b1;
                    sq_d.ch     = req_idx;
                    sq_d.addr   = {1'b0, req_ptr};
                    sq_d.first  = 1'b1;
                    sq_d.st     = WS_FETCH;
                end
            end
            WS_FETCH: begin
                sq_d.st = WS_LATCH;
            end
            WS_LATCH: begin
                if (sq_q.first) begin
                    if (mem_rd_data[END_BIT]) begin
                        done    = 1'b1;
                        sq_d.st = WS_IDLE;
                    end else if (ctl_size == '0 || ctl_next > TOP) begin
                        done    = 1'b1;
                        fault   = 1'b1;
                        sq_d.st = WS_IDLE;
                    end else begin
                        rem_new       = ctl_size - SIZE_W'(1);
                        sq_d.ent_next = ctl_next;
                        sq_d.remain   = rem_new;
                        sq_d.data     = mem_rd_data;
                        sq_d.last     = (rem_new == '0);
                        sq_d.valid    = 1'b1;
                        sq_d.st       = WS_SEND;
                    end
                end else begin
                    sq_d.data  = mem_rd_data;
                    sq_d.last  = (sq_q.remain == '0);
                    sq_d.valid = 1'b1;
                    sq_d.st    = WS_SEND;
                end
            end
            WS_SEND: begin
                if (out_ready) begin
                    sq_d.valid = 1'b0;
                    if (sq_q.last) begin
                        if (sq_q.ent_next >= TOP) begin
                            done    = 1'b1;
                            fault   = 1'b1;
                            sq_d.st = WS_IDLE;
                        end else begin
                            sq_d.addr  = sq_q.ent_next;
                            sq_d.first = 1'b1;
                            sq_d.st    = WS_FETCH;
                        end
                    end else begin
                        sq_d.addr   = sq_q.addr + PW'(1);
                        sq_d.first  = 1'b0;
                        sq_d.remain = sq_q.remain - SIZE_W'(1);
                        sq_d.st     = WS_FETCH;
                    end
                end
            end
            default: sq_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{st: WS_IDLE, ch: '0, addr: '0, ent_next: '0, remain: '0,
                      first: 1'b0, last: 1'b0, valid: 1'b0, data: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign cur_ch      = sq_q.ch;
    assign mem_rd_en   = (sq_q.st == WS_FETCH);
    assign mem_rd_addr = sq_q.addr[AW-1:0];
    assign out_valid   = sq_q.valid;
    assign out_data    = sq_q.data;
    assign out_first   = sq_q.first;
    assign out_last    = sq_q.last;
    assign out_chan    = sq_q.ch;

    // R7: a stalled word holds steady
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_first) && $stable(out_last) && $stable(out_chan)));

    // R4: an end word is never followed by a streamed word
    p_end_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == WS_LATCH && sq_q.first && mem_rd_data[END_BIT]) |=> !out_valid);

    // R3: after an entry's last word the next word needs a fresh read
    p_gap_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R9: a zero-size control word is never streamed
    p_zero_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == WS_LATCH && sq_q.first && !mem_rd_data[END_BIT] && ctl_size == '0)
            |=> !out_valid);

endmodule

// File: rtl/dlw_wr_guard.sv
module dlw_wr_guard #(
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int RSVD = 32
) (
    input  logic          host_wr_en,
    input  logic [AW-1:0] host_wr_addr,
    input  logic [DW-1:0] host_wr_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data
);

    localparam logic [AW-1:0] FLOOR = AW'(RSVD);

    always_comb begin
        mem_wr_en   = host_wr_en && (host_wr_addr >= FLOOR);
        mem_wr_addr = host_wr_addr;
        mem_wr_data = host_wr_data;
    end

endmodule

// File: rtl/dl_walker.sv
module dl_walker
    import dlw_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int NCH      = 3,
    parameter int RSVD     = 32,
    parameter int END_BIT  = 31,
    parameter int SIZE_LSB = 24,
    parameter int SIZE_W   = 6,
    localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ch_enable,
    input  logic [NCH-1:0]   ch_oneshot,
    input  logic [NCH-1:0]   frame_start,
    input  logic [NCH-1:0]   ptr_load,
    input  logic [AW-1:0]    ptr_data,
    output logic [2*NCH-1:0] ch_mode,
    output logic [NCH-1:0]   ch_err,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [DW-1:0]    mem_rd_data,
    input  logic             host_wr_en,
    input  logic [AW-1:0]    host_wr_addr,
    input  logic [DW-1:0]    host_wr_data,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [DW-1:0]    mem_wr_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    out_data,
    output logic             out_first,
    output logic             out_last,
    output logic [CHW-1:0]   out_chan
);

    logic [NCH-1:0] req_v;
    logic [NCH-1:0] busy_v;
    logic [NCH-1:0] arb_grant;
    logic [CHW-1:0] arb_idx;
    logic           arb_any;
    logic [AW-1:0]  ptr_v [NCH];
    logic [AW-1:0]  sel_ptr;
    logic           seq_take;
    logic           seq_done;
    logic           seq_fault;
    logic [CHW-1:0] seq_ch;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ch_mode_e mode_i;

        dlw_chan_ctrl #(.AW(AW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable      (ch_enable[i]),
            .oneshot     (ch_oneshot[i]),
            .frame_start (frame_start[i]),
            .ptr_load    (ptr_load[i]),
            .ptr_data    (ptr_data),
            .grant       (seq_take && arb_grant[i]),
            .done        (seq_done && (seq_ch == CHW'(i))),
            .fault       (seq_fault),
            .mode        (mode_i),
            .err         (ch_err[i]),
            .req         (req_v[i]),
            .busy        (busy_v[i]),
            .ptr         (ptr_v[i])
        );

        assign ch_mode[2*i +: 2] = mode_i;
    end

    dlw_arbiter #(.NCH(NCH)) u_arb (
        .req   (req_v),
        .grant (arb_grant),
        .idx   (arb_idx),
        .any   (arb_any)
    );

    always_comb begin
        sel_ptr = '0;
        for (int i = 0; i < NCH; i++) begin
            if (arb_grant[i]) sel_ptr = ptr_v[i];
        end
    end

    dlw_seq #(
        .AW(AW), .DW(DW), .NCH(NCH),
        .END_BIT(END_BIT), .SIZE_LSB(SIZE_LSB), .SIZE_W(SIZE_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_req     (arb_any),
        .req_idx     (arb_idx),
        .req_ptr     (sel_ptr),
        .take        (seq_take),
        .done        (seq_done),
        .fault       (seq_fault),
        .cur_ch      (seq_ch),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_first   (out_first),
        .out_last    (out_last),
        .out_chan    (out_chan)
    );

    dlw_wr_guard #(.AW(AW), .DW(DW), .RSVD(RSVD)) u_guard (
        .host_wr_en   (host_wr_en),
        .host_wr_addr (host_wr_addr),
        .host_wr_data (host_wr_data),
        .mem_wr_en    (mem_wr_en),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data)
    );

    // R8: at most one channel is in service at any time
    p_one_in_service_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_v));

    // R11: no write ever lands in the reserved words
    p_rsvd_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_addr < AW'(RSVD)) |-> !mem_wr_en);

    // R1: nothing streams out of reset
    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !mem_rd_en));

endmodule

// File: tb/test_dl_walker.sv
module test_dl_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ch_enable = '0, ch_oneshot = '0, frame_start = '0, ptr_load = '0;
    logic [11:0] ptr_data = '0;
    logic [5:0]  ch_mode;
    logic [2:0]  ch_err;
    logic        mem_rd_en;
    logic [11:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        host_wr_en = 1'b0;
    logic [11:0] host_wr_addr = '0;
    logic [31:0] host_wr_data = '0;
    logic        mem_wr_en;
    logic [11:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        out_valid, out_first, out_last;
    logic        out_ready;
    logic [31:0] out_data;
    logic [1:0]  out_chan;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dl_walker i_dl_walker (
        .clk, .rst_n, .ch_enable, .ch_oneshot, .frame_start, .ptr_load, .ptr_data,
        .ch_mode, .ch_err, .mem_rd_en, .mem_rd_addr, .mem_rd_data,
        .host_wr_en, .host_wr_addr, .host_wr_data, .mem_wr_en, .mem_wr_addr, .mem_wr_data,
        .out_valid, .out_ready, .out_data, .out_first, .out_last, .out_chan
    );

    // list memory model: one-cycle synchronous read
    logic [31:0] mem [4096];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end

    // downstream ready pattern
    logic       bp_on = 1'b0;
    logic [1:0] cyc = '0;
    always @(negedge clk) cyc <= cyc + 2'd1;
    assign out_ready = bp_on ? (cyc != 2'd0) : 1'b1;

    // stream collector and hold monitor
    logic [35:0] got_q [$];
    logic [35:0] exp_q [$];
    logic        stall_prev = 1'b0;
    logic [35:0] stall_word;
    int          hold_bad = 0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (stall_prev && !(out_valid && {out_chan, out_first, out_last, out_data} == stall_word))
                hold_bad <= hold_bad + 1;
            stall_prev <= out_valid && !out_ready;
            stall_word <= {out_chan, out_first, out_last, out_data};
            if (out_valid && out_ready)
                got_q.push_back({out_chan, out_first, out_last, out_data});
        end
    end

    function automatic logic [31:0] ctl(input int size, input int tag);
        return (32'(size) << 24) | 32'(tag);
    endfunction

    localparam logic [31:0] ENDW = 32'h8000_0000;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // bench model of a list walk over its own memory image
    task automatic model_walk(input int ch, input int p0);
        int p;
        int s;
        int guard;
        logic [31:0] w;
        p = p0;
        guard = 0;
        while (guard < 300) begin
            guard++;
            w = mem[p];
            if (w[31]) break;
            s = int'(w[29:24]);
            if (s == 0 || p + s > 4096) break;
            for (int k = 0; k < s; k++)
                exp_q.push_back({2'(ch), (k == 0), (k == s - 1), mem[p + k]});
            p = p + s;
            if (p >= 4096) break;
        end
    endtask

    task automatic cmp_stream(input string req);
        chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size()) begin
            for (int i = 0; i < got_q.size(); i++)
                chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
        end
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic hw(input int a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = 12'(a); host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic load_ptr(input int ch, input int p);
        @(negedge clk);
        ptr_load = 3'b001 << ch; ptr_data = 12'(p);
        @(negedge clk);
        ptr_load = '0;
    endtask

    task automatic pulse_fs(input logic [2:0] m);
        @(negedge clk);
        frame_start = m;
        @(negedge clk);
        frame_start = '0;
    endtask

    task automatic wait_walks(input logic [2:0] m);
        for (int n = 0; n < 4000; n++) begin
            bit act;
            act = 1'b0;
            for (int c = 0; c < 3; c++)
                if (m[c] && ch_mode[2*c +: 2] == 2'd2) act = 1'b1;
            if (!act) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [1:0] mode_of(input int c);
        return ch_mode[2*c +: 2];
    endfunction

    // vectors: {channel, start pointer, oneshot, expected mode, expected error}
    localparam int NV = 9;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 12'd100,  1'b0, 2'd1, 1'b0},
        {2'd1, 12'd200,  1'b0, 2'd1, 1'b0},
        {2'd2, 12'd300,  1'b0, 2'd1, 1'b0},
        {2'd0, 12'd10,   1'b0, 2'd1, 1'b0},
        {2'd1, 12'd400,  1'b0, 2'd3, 1'b1},
        {2'd2, 12'd4090, 1'b0, 2'd3, 1'b1},
        {2'd0, 12'd4094, 1'b0, 2'd3, 1'b1},
        {2'd1, 12'd200,  1'b1, 2'd3, 1'b0},
        {2'd2, 12'd100,  1'b1, 2'd3, 1'b0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        // reserved-region list, preloaded as boot contents
        mem[10] = ctl(2, 'h10); mem[11] = 32'h0000_1111; mem[12] = ENDW;

        repeat (3) @(negedge clk);
        // R1: reset state
        for (int c = 0; c < 3; c++) begin
            chk(mode_of(c) == 2'd0, "R1 mode", mode_of(c), 0);
        end
        chk(ch_err == 3'b000, "R1 err", ch_err, 0);
        chk(!out_valid && !mem_rd_en, "R1 idle outputs", {out_valid, mem_rd_en}, 0);
        rst_n = 1'b1;

        // R11: write guard at the ports
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = 12'd5; host_wr_data = 32'hDEAD_BEEF;
        #1 chk(mem_wr_en == 1'b0, "R11 reserved write blocked", mem_wr_en, 0);
        host_wr_addr = 12'd31;
        #1 chk(mem_wr_en == 1'b0, "R11 word 31 blocked", mem_wr_en, 0);
        host_wr_addr = 12'd32; host_wr_data = 32'h0;
        #1 chk(mem_wr_en == 1'b1, "R11 word 32 passes", mem_wr_en, 1);
        @(negedge clk);
        host_wr_en = 1'b0;
        chk(mem[5] == 32'h0, "R11 reserved word unchanged", mem[5], 0);

        // lists written through the host port
        hw(100, ctl(3, 'hA0)); hw(101, 32'hA1); hw(102, 32'hA2);
        hw(103, ctl(1, 'hA3)); hw(104, ENDW);
        hw(200, ctl(2, 'hB0)); hw(201, 32'hB1); hw(202, ctl(4, 'hB2));
        hw(203, 32'hB3); hw(204, 32'hB4); hw(205, 32'hB5); hw(206, ENDW);
        hw(300, ENDW);
        hw(400, ctl(2, 'hD0)); hw(401, 32'hD1); hw(402, ctl(0, 'hD2)); hw(403, 32'hD3);
        hw(4090, ctl(3, 'hE0)); hw(4091, 32'hE1); hw(4092, 32'hE2);
        hw(4093, ctl(3, 'hE3)); hw(4094, 32'hE4); hw(4095, 32'hE5);

        // R2: enabling arms
        @(negedge clk);
        ch_enable = 3'b111;
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            chk(mode_of(c) == 2'd1, "R2 armed after enable", mode_of(c), 1);
        end

        // vector loop: R3 R4 R5 R9 R10 R12
        for (int v = 0; v < NV; v++) begin
            int ch;
            int p;
            ch = int'(VEC[v][17:16]);
            p  = int'(VEC[v][15:4]);
            bp_on = v[0];
            @(negedge clk);
            ch_oneshot[ch] = VEC[v][3];
            load_ptr(ch, p);
            model_walk(ch, p);
            pulse_fs(3'b001 << ch);
            wait_walks(3'b001 << ch);
            cmp_stream("R3/R4 stream");
            chk(mode_of(ch) == VEC[v][2:1], "R5/R9/R10 mode", mode_of(ch), VEC[v][2:1]);
            chk(ch_err[ch] == VEC[v][0], "R9/R10 err", ch_err[ch], VEC[v][0]);
            if (VEC[v][2:1] == 2'd3) begin
                // R6: frame start on a stopped channel is ignored
                pulse_fs(3'b001 << ch);
                repeat (20) @(negedge clk);
                chk(got_q.size() == 0, "R6 stopped channel silent", got_q.size(), 0);
                chk(mode_of(ch) == 2'd3, "R6 mode unchanged", mode_of(ch), 3);
                chk(ch_err[ch] == VEC[v][0], "R9 err sticky", ch_err[ch], VEC[v][0]);
            end
            // R12: disable clears
            ch_enable[ch] = 1'b0;
            ch_oneshot[ch] = 1'b0;
            @(negedge clk);
            chk(mode_of(ch) == 2'd0 && ch_err[ch] == 1'b0, "R12 disable clears",
                {mode_of(ch), ch_err[ch]}, 0);
            ch_enable[ch] = 1'b1;
            @(negedge clk);
            chk(mode_of(ch) == 2'd1, "R2 re-armed", mode_of(ch), 1);
        end

        // R6: disabled channel ignores frame start
        @(negedge clk);
        ch_enable[2] = 1'b0;
        load_ptr(2, 100);
        pulse_fs(3'b100);
        repeat (20) @(negedge clk);
        chk(got_q.size() == 0, "R6 disabled channel silent", got_q.size(), 0);
        chk(mode_of(2) == 2'd0, "R6 disabled mode", mode_of(2), 0);
        ch_enable[2] = 1'b1;
        @(negedge clk);

        // R8: three frame starts together, with backpressure
        bp_on = 1'b1;
        load_ptr(0, 200);
        load_ptr(1, 100);
        load_ptr(2, 10);
        model_walk(0, 200);
        model_walk(1, 100);
        model_walk(2, 10);
        pulse_fs(3'b111);
        wait_walks(3'b111);
        cmp_stream("R8 priority order");
        for (int c = 0; c < 3; c++) begin
            chk(mode_of(c) == 2'd1, "R8 all re-armed", mode_of(c), 1);
        end

        // R8: channels 1 and 2 requested while channel 0 is walking
        bp_on = 1'b0;
        load_ptr(2, 200);
        load_ptr(1, 10);
        model_walk(0, 200);
        model_walk(1, 10);
        model_walk(2, 200);
        pulse_fs(3'b001);
        pulse_fs(3'b110);
        wait_walks(3'b111);
        cmp_stream("R8 pending during walk");

        // R2: pointer reload mid-walk does not disturb the walk
        load_ptr(0, 200);
        model_walk(0, 200);
        pulse_fs(3'b001);
        repeat (4) @(negedge clk);
        load_ptr(0, 100);
        wait_walks(3'b001);
        cmp_stream("R2 pointer captured at pickup");
        model_walk(0, 100);
        pulse_fs(3'b001);
        wait_walks(3'b001);
        cmp_stream("R2 new pointer used next frame");

        // R7: stalled words held steady
        chk(hold_bad == 0, "R7 stall hold", hold_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule